// File: doc/BRIEF.md
# Stereo Column Slice Buffer

This block sits at the front of a stereo window-matching pipeline. It takes two raster pixel streams that arrive in lockstep, one from the left camera and one from the right camera, under a shared valid strobe and a frame-start marker. Each stream feeds a single linear shift chain. That chain reaches back WIN_H-1 full scan lines, and on the right side it reaches back a further MAX_DISP pixels.

After every accepted pixel the block presents two kinds of column slice, each WIN_H pixels tall. The first is one slice from the left image at the current column. The second is a set of MAX_DISP+1 slices from the right image, one for each candidate disparity d from 0 to MAX_DISP. The right slice for disparity d is taken d columns to the left of the current position, in the same rows. A downstream matching stage collects these slices across WIN_W columns to form windows.

The block also produces a one-cycle strobe that marks a complete column, and it reports the current column index. It carries one flag per disparity that says whether a window of WIN_W columns ending at that slice stays inside the image. Slices whose window would wrap into the previous line are flagged invalid rather than suppressed.

Top module: `stereo_slice_buffer`

## Requirements
- R1: After reset, slice_valid_o, left_ok_o and every bit of disp_ok_o are 0, and col_o is 0.
- R2: A cycle with pix_valid_i low accepts nothing. In the following cycle slice_valid_o, left_ok_o and disp_ok_o are 0, and left_col_o, right_cols_o and col_o keep their values.
- R3: frame_start_i is sampled only together with pix_valid_i. The pixel accepted with it is row 0, column 0 of a new frame, so col_o reads 0 in the next cycle.
- R4: slice_valid_o is high in the cycle after an accepted pixel exactly when that pixel belongs to a started frame and lies in row WIN_H-1 or later. Otherwise it is low.
- R5: Element r of left_col_o, at bits [r*PIX_W +: PIX_W], is the left pixel r rows above the newest accepted pixel in the same column. Element 0 is the newest pixel itself.
- R6: Element r of slice d in right_cols_o, at bits [(d*WIN_H+r)*PIX_W +: PIX_W], is the right pixel r rows above and d columns left of the newest pixel, for d from 0 to MAX_DISP.
- R7: left_ok_o is 1 exactly when slice_valid_o is 1 and col_o >= WIN_W-1. Bit d of disp_ok_o is 1 exactly when slice_valid_o is 1 and col_o >= WIN_W-1+d.
- R8: A frame start in the middle of a frame restarts the line count. slice_valid_o then stays low until row WIN_H-1 of the new frame.
- R9: Pixels accepted before the first frame start never raise slice_valid_o and leave col_o at 0.
- R10: Within a started frame the column advances by one per accepted pixel and wraps from LINE_W-1 back to 0 on the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| pix_valid_i | input | 1 | Both pixel inputs carry a pixel this cycle |
| frame_start_i | input | 1 | The accepted pixel is the first of a frame |
| left_pix_i | input | PIX_W | Left camera pixel, unsigned |
| right_pix_i | input | PIX_W | Right camera pixel, unsigned |
| slice_valid_o | output | 1 | The slices describe a complete column (one-cycle strobe) |
| col_o | output | $clog2(LINE_W) | Column of the newest accepted pixel |
| left_ok_o | output | 1 | The left window ending at this column is inside the image |
| disp_ok_o | output | MAX_DISP+1 | Per disparity, the right window is inside the image |
| left_col_o | output | WIN_H*PIX_W | Left column slice, element 0 is the current row |
| right_cols_o | output | (MAX_DISP+1)*WIN_H*PIX_W | Right column slices, disparity-major |

## Verification
The bench builds the block with LINE_W=8, WIN_H=3, WIN_W=3 and MAX_DISP=3. With these values a whole frame is only a few dozen pixels, so every line wrap and every row of the fill-up phase is reached in a short run. Each disparity's edge flag turns on at a different column, and each of those columns is checked. The pixel values are distinct per position, so a tap that lands one row or one column off gives a visible mismatch. This covers both the plain right slice and the slice at the largest disparity, whose chain tail is longest.

// File: rtl/stereo_sb_pkg.sv
package stereo_sb_pkg;

    // Number of chain stages needed so that a tap reaching back
    // (win_h-1) lines and (ndisp-1) extra pixels exists.
    function automatic int chain_depth(input int line_w, input int win_h, input int ndisp);
        return line_w * (win_h - 1) + ndisp;
    endfunction

    // Chain position holding the pixel r rows up and d columns back.
    function automatic int tap_pos(input int line_w, input int r, input int d);
        return r * line_w + d;
    endfunction

endpackage

// File: rtl/stereo_sb_tap_chain.sv
module stereo_sb_tap_chain #(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 240,
    parameter int WIN_H  = 9,
    parameter int NDISP  = 32
) (
    input  logic                          clk,
    input  logic                          shift_i,
    input  logic [PIX_W-1:0]              pix_i,
    output logic [NDISP*WIN_H*PIX_W-1:0]  taps_o
);
    localparam int DEPTH = stereo_sb_pkg::chain_depth(LINE_W, WIN_H, NDISP);

    typedef struct packed {
        logic [DEPTH-1:0][PIX_W-1:0] line;
    } chain_t;

    chain_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_i) begin
            s_d.line = {s_q.line[DEPTH-2:0], pix_i};
        end
    end

    // Pixel storage carries no reset: its contents only matter once the
    // tracker has counted enough lines, which it does from a reset state.
    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    for (genvar d = 0; d < NDISP; d++) begin : g_disp
        for (genvar r = 0; r < WIN_H; r++) begin : g_row
            localparam int IDX = stereo_sb_pkg::tap_pos(LINE_W, r, d);
            assign taps_o[(d*WIN_H + r)*PIX_W +: PIX_W] = s_q.line[IDX];
        end
    end

endmodule

// File: rtl/stereo_sb_raster_track.sv
module stereo_sb_raster_track #(
    parameter int LINE_W   = 240,
    parameter int WIN_H    = 9,
    parameter int WIN_W    = 9,
    parameter int MAX_DISP = 31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_i,
    input  logic                       sof_i,
    output logic                       valid_o,
    output logic [$clog2(LINE_W)-1:0]  col_o,
    output logic                       left_ok_o,
    output logic [MAX_DISP:0]          disp_ok_o
);
    localparam int COL_W = $clog2(LINE_W);
    localparam int LN_W  = $clog2(WIN_H + 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_W - 1);
    localparam logic [LN_W-1:0]  FULL     = LN_W'(WIN_H - 1);

    typedef struct packed {
        logic               live;
        logic [COL_W-1:0]   col;
        logic [LN_W-1:0]    lines;
        logic               valid;
        logic               left_ok;
        logic [MAX_DISP:0]  disp_ok;
    } track_t;

    track_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.valid   = 1'b0;
        s_d.left_ok = 1'b0;
        s_d.disp_ok = '0;
        if (accept_i) begin
            if (sof_i) begin
                s_d.live  = 1'b1;
                s_d.col   = '0;
                s_d.lines = '0;
            end else if (s_q.live) begin
                if (s_q.col == LAST_COL) begin
                    s_d.col = '0;
                    if (s_q.lines != FULL) begin
                        s_d.lines = s_q.lines + 1'b1;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
            if (s_d.live && (s_d.lines == FULL)) begin
                s_d.valid   = 1'b1;
                s_d.left_ok = (int'(s_d.col) >= WIN_W - 1);
                for (int d = 0; d <= MAX_DISP; d++) begin
                    s_d.disp_ok[d] = (int'(s_d.col) >= WIN_W - 1 + d);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o   = s_q.valid;
    assign col_o     = s_q.col;
    assign left_ok_o = s_q.left_ok;
    assign disp_ok_o = s_q.disp_ok;

endmodule

// File: rtl/stereo_slice_buffer.sv
module stereo_slice_buffer #(
    parameter int PIX_W    = 8,
    parameter int LINE_W   = 240,
    parameter int WIN_H    = 9,
    parameter int WIN_W    = 9,
    parameter int MAX_DISP = 31
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  pix_valid_i,
    input  logic                                  frame_start_i,
    input  logic [PIX_W-1:0]                      left_pix_i,
    input  logic [PIX_W-1:0]                      right_pix_i,
    output logic                                  slice_valid_o,
    output logic [$clog2(LINE_W)-1:0]             col_o,
    output logic                                  left_ok_o,
    output logic [MAX_DISP:0]                     disp_ok_o,
    output logic [WIN_H*PIX_W-1:0]                left_col_o,
    output logic [(MAX_DISP+1)*WIN_H*PIX_W-1:0]   right_cols_o
);
    localparam int NDISP = MAX_DISP + 1;

    // Left side only needs the current column; the disparity tail is
    // kept on the right chain alone.
    stereo_sb_tap_chain #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W),
        .WIN_H (WIN_H),
        .NDISP (1)
    ) u_left_chain (
        .clk    (clk),
        .shift_i(pix_valid_i),
        .pix_i  (left_pix_i),
        .taps_o (left_col_o)
    );

    stereo_sb_tap_chain #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W),
        .WIN_H (WIN_H),
        .NDISP (NDISP)
    ) u_right_chain (
        .clk    (clk),
        .shift_i(pix_valid_i),
        .pix_i  (right_pix_i),
        .taps_o (right_cols_o)
    );

    stereo_sb_raster_track #(
        .LINE_W  (LINE_W),
        .WIN_H   (WIN_H),
        .WIN_W   (WIN_W),
        .MAX_DISP(MAX_DISP)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (pix_valid_i),
        .sof_i    (frame_start_i),
        .valid_o  (slice_valid_o),
        .col_o    (col_o),
        .left_ok_o(left_ok_o),
        .disp_ok_o(disp_ok_o)
    );

endmodule

// File: rtl/stereo_slice_buffer_chk.sv
module stereo_slice_buffer_chk #(
    parameter int PIX_W    = 8,
    parameter int LINE_W   = 240,
    parameter int WIN_H    = 9,
    parameter int MAX_DISP = 31
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  pix_valid_i,
    input logic                                  frame_start_i,
    input logic [PIX_W-1:0]                      left_pix_i,
    input logic [PIX_W-1:0]                      right_pix_i,
    input logic                                  slice_valid_o,
    input logic [$clog2(LINE_W)-1:0]             col_o,
    input logic                                  left_ok_o,
    input logic [MAX_DISP:0]                     disp_ok_o,
    input logic [WIN_H*PIX_W-1:0]                left_col_o,
    input logic [(MAX_DISP+1)*WIN_H*PIX_W-1:0]   right_cols_o
);

    p_strobe_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slice_valid_o |-> $past(pix_valid_i));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> ($stable(left_col_o) && $stable(right_cols_o)
                          && $stable(col_o) && !slice_valid_o));

    p_sof_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && frame_start_i) |=> (col_o == '0));

    p_sof_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && frame_start_i) |=> !slice_valid_o);

    p_left_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> (left_col_o[PIX_W-1:0] == $past(left_pix_i)));

    p_right_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> (right_cols_o[PIX_W-1:0] == $past(right_pix_i)));

    p_flags_need_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_valid_o |-> (!left_ok_o && (disp_ok_o == '0)));

    p_disp0_matches_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ok_o[0] |-> left_ok_o);

    for (genvar d = 0; d < MAX_DISP; d++) begin : g_order
        p_disp_thermo_r7: assert property (@(posedge clk) disable iff (!rst_n)
            disp_ok_o[d+1] |-> disp_ok_o[d]);
    end

endmodule

bind stereo_slice_buffer stereo_slice_buffer_chk #(
    .PIX_W   (PIX_W),
    .LINE_W  (LINE_W),
    .WIN_H   (WIN_H),
    .MAX_DISP(MAX_DISP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid_i  (pix_valid_i),
    .frame_start_i(frame_start_i),
    .left_pix_i   (left_pix_i),
    .right_pix_i  (right_pix_i),
    .slice_valid_o(slice_valid_o),
    .col_o        (col_o),
    .left_ok_o    (left_ok_o),
    .disp_ok_o    (disp_ok_o),
    .left_col_o   (left_col_o),
    .right_cols_o (right_cols_o)
);

// File: tb/stereo_slice_buffer_tb_top.sv
`timescale 1ns/1ps
module stereo_slice_buffer_tb_top;
    localparam int PIX_W    = 8;
    localparam int LINE_W   = 8;
    localparam int WIN_H    = 3;
    localparam int WIN_W    = 3;
    localparam int MAX_DISP = 3;
    localparam int COL_W    = $clog2(LINE_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid_i = 1'b0;
    logic frame_start_i = 1'b0;
    logic [PIX_W-1:0] left_pix_i = '0;
    logic [PIX_W-1:0] right_pix_i = '0;
    logic slice_valid_o;
    logic [COL_W-1:0] col_o;
    logic left_ok_o;
    logic [MAX_DISP:0] disp_ok_o;
    logic [WIN_H*PIX_W-1:0] left_col_o;
    logic [(MAX_DISP+1)*WIN_H*PIX_W-1:0] right_cols_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stereo_slice_buffer #(
        .PIX_W(PIX_W), .LINE_W(LINE_W), .WIN_H(WIN_H),
        .WIN_W(WIN_W), .MAX_DISP(MAX_DISP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
        .frame_start_i(frame_start_i), .left_pix_i(left_pix_i),
        .right_pix_i(right_pix_i), .slice_valid_o(slice_valid_o),
        .col_o(col_o), .left_ok_o(left_ok_o), .disp_ok_o(disp_ok_o),
        .left_col_o(left_col_o), .right_cols_o(right_cols_o)
    );

    function automatic logic [7:0] lpix(int f, int y, int x);
        return 8'((f*37 + y*11 + x*3 + 5) & 255);
    endfunction

    function automatic logic [7:0] rpix(int f, int y, int x);
        return 8'((f*53 + y*7 + x*13 + 100) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle worth of inputs, then wait until the edge has taken them.
    task automatic drive(bit v, bit sof, logic [7:0] l, logic [7:0] r);
        pix_valid_i   = v;
        frame_start_i = sof;
        left_pix_i    = l;
        right_pix_i   = r;
        @(negedge clk);
    endtask

    task automatic check_pix(int f, int y, int x, bit live);
        bit exp_v;
        exp_v = live && (y >= WIN_H - 1);
        chk(slice_valid_o == exp_v, "R4", "slice_valid", int'(slice_valid_o), int'(exp_v));
        if (live) chk(int'(col_o) == x, "R10", "col", int'(col_o), x);
        else      chk(col_o == '0, "R9", "col idle", int'(col_o), 0);
        chk(left_ok_o == (exp_v && x >= WIN_W - 1), "R7", "left_ok",
            int'(left_ok_o), int'(exp_v && x >= WIN_W - 1));
        for (int d = 0; d <= MAX_DISP; d++) begin
            chk(disp_ok_o[d] == (exp_v && x >= WIN_W - 1 + d), "R7", $sformatf("disp_ok[%0d]", d),
                int'(disp_ok_o[d]), int'(exp_v && x >= WIN_W - 1 + d));
        end
        if (exp_v) begin
            for (int r = 0; r < WIN_H; r++) begin
                chk(left_col_o[r*PIX_W +: PIX_W] == lpix(f, y - r, x), "R5",
                    $sformatf("left row %0d", r),
                    int'(left_col_o[r*PIX_W +: PIX_W]), int'(lpix(f, y - r, x)));
                for (int d = 0; d <= MAX_DISP; d++) begin
                    if (x >= d) begin
                        chk(right_cols_o[(d*WIN_H + r)*PIX_W +: PIX_W] == rpix(f, y - r, x - d), "R6",
                            $sformatf("right d%0d row %0d", d, r),
                            int'(right_cols_o[(d*WIN_H + r)*PIX_W +: PIX_W]),
                            int'(rpix(f, y - r, x - d)));
                    end
                end
            end
        end
    endtask

    task automatic push(int f, int y, int x, bit sof, bit live);
        drive(1'b1, sof, lpix(f, y, x), rpix(f, y, x));
        check_pix(f, y, x, live);
    endtask

    task automatic test_reset();
        chk(slice_valid_o == 1'b0, "R1", "slice_valid after reset", int'(slice_valid_o), 0);
        chk(col_o == '0, "R1", "col after reset", int'(col_o), 0);
        chk(left_ok_o == 1'b0, "R1", "left_ok after reset", int'(left_ok_o), 0);
        chk(disp_ok_o == '0, "R1", "disp_ok after reset", int'(disp_ok_o), 0);
    endtask

    task automatic test_no_frame();
        // frame start without valid must not open a frame (R3), and
        // pixels outside a frame never complete a slice (R9)
        drive(1'b0, 1'b1, 8'h11, 8'h22);
        for (int i = 0; i < 3 * LINE_W; i++) begin
            push(0, i / LINE_W, i % LINE_W, 1'b0, 1'b0);
        end
        chk(slice_valid_o == 1'b0, "R3", "sof without valid ignored", int'(slice_valid_o), 0);
    endtask

    task automatic test_full_frame();
        for (int y = 0; y < 5; y++) begin
            for (int x = 0; x < LINE_W; x++) begin
                push(1, y, x, (y == 0 && x == 0), 1'b1);
                if (y == 0 && x == 0)
                    chk(col_o == '0, "R3", "col at frame start", int'(col_o), 0);
            end
        end
    endtask

    task automatic test_gaps();
        logic [WIN_H*PIX_W-1:0] l_snap;
        logic [(MAX_DISP+1)*WIN_H*PIX_W-1:0] r_snap;
        logic [COL_W-1:0] c_snap;
        for (int y = 0; y < 4; y++) begin
            for (int x = 0; x < LINE_W; x++) begin
                push(2, y, x, (y == 0 && x == 0), 1'b1);
                if (x == 4) begin
                    l_snap = left_col_o;
                    r_snap = right_cols_o;
                    c_snap = col_o;
                    for (int g = 0; g < 2; g++) begin
                        drive(1'b0, 1'b0, 8'hEE, 8'hDD);
                        chk(slice_valid_o == 1'b0, "R2", "strobe in gap", int'(slice_valid_o), 0);
                        chk(disp_ok_o == '0, "R2", "disp_ok in gap", int'(disp_ok_o), 0);
                        chk(left_col_o == l_snap, "R2", "left taps held", int'(left_col_o[7:0]), int'(l_snap[7:0]));
                        chk(right_cols_o == r_snap, "R2", "right taps held",
                            int'(right_cols_o[7:0]), int'(r_snap[7:0]));
                        chk(col_o == c_snap, "R2", "col held", int'(col_o), int'(c_snap));
                    end
                end
            end
        end
    endtask

    task automatic test_restart();
        for (int i = 0; i < 2 * LINE_W + 4; i++) begin
            push(3, i / LINE_W, i % LINE_W, (i == 0), 1'b1);
        end
        // new frame begins mid-line; R8: no slice until row WIN_H-1 again
        for (int y = 0; y < 4; y++) begin
            for (int x = 0; x < LINE_W; x++) begin
                push(4, y, x, (y == 0 && x == 0), 1'b1);
                if (y < WIN_H - 1)
                    chk(slice_valid_o == 1'b0, "R8", "no slice after restart",
                        int'(slice_valid_o), 0);
            end
        end
        drive(1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_no_frame();
        test_full_frame();
        test_gaps();
        test_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule